// File: doc/BRIEF.md
# Refresh-Snooped Memory Page Register

This block holds a small memory page number that drives the upper lines of an external memory address. It is loaded without any I/O port decode: during every refresh cycle the processor puts its interrupt-vector register on the high byte of the address bus and the refresh counter on the low byte. The block watches for the start of each refresh strobe and copies four bits of that high byte into the page register. Software selects a page by writing the vector register, and then runs one no-op instruction so that the next refresh cycle carries the new value.

Capture is gated by the top bit of the refresh counter, which is address bit 7. While that bit is high, refresh cycles leave the page unchanged. Software can therefore set refresh-counter bit 7 and then use the vector register as a vectored-interrupt table base without disturbing the page. All inputs are sampled on the system clock. Reset is asynchronous and active low.

Top module: `rfsh_page_latch`

## Requirements
- R1: While reset is asserted, and after it is released, `page` reads 0 until the first capture.
- R2: The capture point is the first rising clock edge at which both `rfsh_n` and `mreq_n` are sampled low after a cycle in which they were not both low. At that point, if `addr[7]` is 0, `page` takes `addr[11:8]`, and the new value is visible right after that edge.
- R3: At a capture point where `addr[7]` is 1, `page` keeps its previous value.
- R4: No other input combination changes `page`. This covers `mreq_n` low with `rfsh_n` high (an ordinary memory access), `rfsh_n` low with `mreq_n` high, and both inputs high, whatever the address.
- R5: There is at most one capture per strobe. Changes on `addr` while both strobes stay low, after the capture point, are ignored.
- R6: Bit order is kept: `addr[8]` drives `page[0]` and `addr[11]` drives `page[3]`.
- R7: In a modelled instruction stream, a vector-register load only shows on `page` at the refresh phase of the next instruction fetch. It does not show during the load's own fetches, nor during the opcode-read phase of the following fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| rfsh_n | input | 1 | Refresh strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| page | output | 4 | Current memory page number |

## Verification
Each result is due one clock edge after the input cycle that causes it. An input driven after edge N is sampled at edge N+1, and `page` is compared at the falling edge that follows. The driver tags every expected value with the cycle count at which it becomes due. The monitor removes an item only once the cycle counter has reached that due count, so no value is checked early. The instruction-stream sequences check every cycle of the no-op fetch. This shows that the page stays old through the opcode-read phase and changes at the refresh edge, not one cycle sooner.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
    typedef struct packed {
        logic strobe;
    } edge_state_t;
endpackage

// File: rtl/rpl_strobe_edge.sv
module rpl_strobe_edge
    import rpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_n,
    input  logic mreq_n,
    output logic fire
);
    edge_state_t st_d, st_q;
    logic        strobe_now;

    always_comb begin
        strobe_now = ~rfsh_n & ~mreq_n;
        st_d       = st_q;
        st_d.strobe = strobe_now;
        fire       = strobe_now & ~st_q.strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R5

    AST_FIRE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (!rfsh_n && !mreq_n)); // R4
endmodule

// File: rtl/rpl_page_reg.sv
module rpl_page_reg #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              gate_hi,
    input  logic [PAGE_W-1:0] page_in,
    output logic [PAGE_W-1:0] page
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } page_state_t;

    page_state_t st_d, st_q;
    logic        load_en;

    always_comb begin
        st_d    = st_q;
        load_en = fire & ~gate_hi;
        if (load_en) st_d.page = page_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page = st_q.page;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(page)); // R4

    AST_HOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && gate_hi) |=> $stable(page)); // R3

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !gate_hi) |=> (page == $past(page_in))); // R2
endmodule

// File: rtl/rfsh_page_latch.sv
module rfsh_page_latch #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 8,
    parameter int PAGE_W   = 4,
    parameter int GATE_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rfsh_n,
    input  logic              mreq_n,
    output logic [PAGE_W-1:0] page
);
    localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

    logic fire;

    rpl_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rfsh_n (rfsh_n),
        .mreq_n (mreq_n),
        .fire   (fire)
    );

    rpl_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .gate_hi (addr[GATE_BIT]),
        .page_in (addr[PAGE_MSB:PAGE_LSB]),
        .page    (page)
    );

    AST_ORDINARY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_n && !mreq_n) |=> $stable(page)); // R4, R7
endmodule

// File: tb/rfsh_page_latch_bench.sv
module rfsh_page_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rfsh_n = 1'b1;
    logic        mreq_n = 1'b1;
    logic [3:0]  page;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int       due;
        logic [3:0] val;
        string    tag;
    } item_t;

    item_t q[$];
    item_t it;
    logic [3:0] exp_page = '0;
    bit         prev_strobe = 1'b0;
    logic [7:0] ireg = '0;
    logic [6:0] rcnt = '0;
    logic       r7 = 1'b0;
    logic [15:0] pc = 16'h0100;

    rfsh_page_latch u_rfsh_page_latch (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .rfsh_n(rfsh_n), .mreq_n(mreq_n), .page(page)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each expectation once its due cycle is reached
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            it = q.pop_front();
            checks++;
            if (page !== it.val) begin
                errors++;
                $display("FAIL %s cycle %0d actual %h expected %h", it.tag, cyc, page, it.val);
            end
        end
    end

    // driver: one bus cycle, with the expected page pushed to the scoreboard
    task automatic drive(input bit rf, input bit mr, input logic [15:0] a, input string tag);
        bit s;
        @(posedge clk); #1;
        rfsh_n = rf; mreq_n = mr; addr = a;
        s = !rf && !mr;
        if (s && !prev_strobe && !a[7]) exp_page = a[11:8];
        prev_strobe = s;
        q.push_back('{cyc + 1, exp_page, tag});
    endtask

    // instruction fetch: two opcode-read cycles, then a refresh phase
    task automatic fetch(input string tag);
        logic [15:0] ra;
        drive(1, 0, pc, {tag, " opcode read"});
        drive(1, 0, pc, {tag, " opcode read"});
        ra = {ireg, r7, rcnt};
        drive(0, 0, ra, {tag, " refresh"});
        drive(0, 1, ra, {tag, " refresh tail"});
        rcnt = rcnt + 7'd1;
        pc = pc + 16'd1;
    endtask

    // two-byte vector-register load; the register changes at its end
    task automatic load_vec(input logic [7:0] v);
        fetch("R7 load prefix");
        fetch("R7 load opcode");
        drive(1, 1, pc, "R7 load exec");
        ireg = v;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (page !== 4'h0) begin
            errors++;
            $display("FAIL R1 in reset actual %h expected 0", page);
        end
        rst_n = 1'b1;
        drive(1, 1, 16'hFFFF, "R1 after reset");
        drive(1, 0, 16'h0F00, "R4 memory access ignored");
        drive(0, 1, 16'h0A00, "R4 refresh without mreq ignored");
        drive(1, 1, 16'h0A00, "R4 idle");

        // direct capture, bit order
        drive(0, 0, 16'h0100, "R6 bit8 to page0");
        drive(1, 1, 16'h0000, "R6 hold");
        drive(0, 0, 16'h0800, "R6 bit11 to page3");
        drive(1, 1, 16'h0000, "R6 hold");
        drive(0, 0, 16'h0500, "R2 capture 5");
        drive(0, 0, 16'h0A00, "R5 addr change within strobe ignored");
        drive(0, 0, 16'h0300, "R5 still ignored");
        drive(1, 1, 16'h0000, "R5 idle");
        drive(0, 0, 16'h0C80, "R3 gate bit high holds");
        drive(1, 1, 16'h0000, "R3 idle");
        drive(0, 0, 16'h0C00, "R2 capture C");
        drive(1, 1, 16'h0000, "R2 idle");

        // instruction stream
        ireg = 8'h00; r7 = 1'b0;
        fetch("R7 plain");
        load_vec(8'h39);
        fetch("R7 nop after load");
        fetch("R7 next");
        load_vec(8'h3E);
        fetch("R7 nop after second load");
        r7 = 1'b1;
        load_vec(8'h47);
        fetch("R3 nop with refresh bit7 set");
        fetch("R3 further fetch");
        r7 = 1'b0;
        fetch("R3 bit7 cleared captures");

        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule